// File: doc/BRIEF.md
# Dual-Mode Infrared Transmit Modulator

This block sits between a UART transmitter and an infrared transceiver. It turns the UART serial output into an infrared drive signal. Two line codes are available, and a mode bit selects between them. The first is the short-pulse code used by low-rate serial infrared links, which handles bit rates up to 115.2 kbps. The second is an amplitude-shift-keyed code that gates a 500 kHz square carrier, which handles bit rates up to 19.2 kbps. In both codes a mark (logic one) produces no emission. The start bit of every character is a zero, so every frame opens with emission.

The UART supplies its 16x baud tick. The block samples the serial bit on each tick, finds bit boundaries itself and counts ticks within the bit. A bit boundary is either a change in the serial value or the sixteenth tick of an unchanged value. The carrier period comes from the clock frequency through parameters. A select bit routes either the infrared drive or the plain serial bit to the single output pin, so the same pin serves a wired serial port. A polarity parameter makes the infrared drive active-high or active-low.

Top module: `ir_tx_modulator`

## Requirements
- R1: After reset, with the serial input held at one and infrared routing selected, the output sits at the inactive level: 0 when ACTIVE_HIGH=1.
- R2: In pulse mode (mode_ask=0), a zero bit makes the drive active from the first clock after the bit's first tick until the clock after its fourth tick. That is PULSE_TICKS=3 of the 16 tick intervals, and the drive is inactive for the rest of the bit.
- R3: In either infrared mode, a one bit gives no emission for the whole bit.
- R4: In carrier mode (mode_ask=1), a zero bit gives a square wave for the whole bit. Its half period is CLK_HZ/(2*CARRIER_HZ) clocks, and its first half is active.
- R5: The carrier phase and the pulse restart at the start of every zero bit. This includes a zero that follows a zero, where the boundary is the sixteenth tick since the last one.
- R6: With en=0 and infrared routing selected, the output stays inactive whatever the serial input and mode are.
- R7: With ir_sel=0, the output equals ser_in in the same cycle, whatever en and mode_ask are.
- R8: With ACTIVE_HIGH=0, the infrared drive is the exact complement of the ACTIVE_HIGH=1 drive for the same stimulus.
- R9: mode_ask selects the code: 0 gives the pulse code and 1 gives the carrier code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Infrared emission enable |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| ser_in | input | 1 | UART serial transmit bit |
| mode_ask | input | 1 | 0 = short pulse code, 1 = gated carrier code |
| ir_sel | input | 1 | 1 = infrared drive on output, 0 = plain serial |
| txd_out | output | 1 | Transmit pin drive |

## Verification
The bit value and tick count are registered on the baud tick. The carrier divider is registered on every clock. The output is decoded from those registers without a further stage, so an infrared result is due one clock after the edge that carries the stimulus. The pass-through path is due in the same cycle. The bench drives inputs at the falling edge and samples a quarter period after each rising edge. It computes the expected level from the bit value, the tick index within the bit and the number of clocks since the bit started, which is where the design's registers have settled.

// File: rtl/ir_tx_modulator.sv
module ir_tx_modulator #(
  parameter int CLK_HZ        = 48_000_000,
  parameter int CARRIER_HZ    = 500_000,
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_TICKS   = 3,
  parameter bit ACTIVE_HIGH   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic baud_tick,
  input  logic ser_in,
  input  logic mode_ask,
  input  logic ir_sel,
  output logic txd_out
);

  localparam int HALF = CLK_HZ / (2 * CARRIER_HZ);
  localparam int CW   = $clog2(TICKS_PER_BIT);
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic          cur_bit;
  logic [CW-1:0] tick_cnt;
  logic [DW-1:0] div_cnt;
  logic          carrier;

  logic bit_wrap, bit_start, zero_start, div_end;
  logic pulse_on, ask_on, emit, ir_lvl;

  assign bit_wrap   = tick_cnt == CW'(TICKS_PER_BIT - 1);
  assign bit_start  = baud_tick & ((ser_in != cur_bit) | bit_wrap);
  assign zero_start = bit_start & ~ser_in;
  assign div_end    = div_cnt == DW'(HALF - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bit  <= 1'b1;
      tick_cnt <= '0;
    end else if (baud_tick) begin
      cur_bit  <= ser_in;
      tick_cnt <= bit_start ? '0 : tick_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      carrier <= 1'b0;
    end else if (zero_start) begin
      div_cnt <= '0;
      carrier <= 1'b1;
    end else if (div_end) begin
      div_cnt <= '0;
      carrier <= ~carrier;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign pulse_on = ~cur_bit & (tick_cnt < CW'(PULSE_TICKS));
  assign ask_on   = ~cur_bit & carrier;
  assign emit     = en & (mode_ask ? ask_on : pulse_on);
  assign ir_lvl   = ACTIVE_HIGH ? emit : ~emit;
  assign txd_out  = ir_sel ? ir_lvl : ser_in;

  p_mark_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && ser_in) |=> !emit);

  p_pulse_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !ser_in && bit_start && !mode_ask && en) |=> emit);

  p_pulse_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !bit_start && tick_cnt == CW'(PULSE_TICKS - 1) && !mode_ask) |=> !emit);

  p_carrier_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> (carrier && div_cnt == '0));

  p_carrier_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_start && !div_end) |=> $stable(carrier));

  p_bit_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && bit_wrap) |=> tick_cnt == '0);

endmodule

// File: tb/test_ir_tx_modulator.sv
module test_ir_tx_modulator;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4_000_000;
  localparam int CARRIER_HZ = 500_000;
  localparam int TD         = 3;
  localparam int NTICK      = 16;
  localparam int PULSE      = 3;
  localparam int HALF_EXP   = CLK_HZ / (2 * CARRIER_HZ);

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, baud_tick = 1'b0;
  logic ser_in = 1'b1, mode_ask = 1'b0, ir_sel = 1'b1;
  logic txd_p, txd_n;
  int total = 0, bad = 0;
  bit prev_b = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ir_tx_modulator #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ), .ACTIVE_HIGH(1'b1)) i_ir_tx_modulator (
    .clk(clk), .rst_n(rst_n), .en(en), .baud_tick(baud_tick), .ser_in(ser_in),
    .mode_ask(mode_ask), .ir_sel(ir_sel), .txd_out(txd_p));

  ir_tx_modulator #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ), .ACTIVE_HIGH(1'b0)) i_ir_tx_modulator_n (
    .clk(clk), .rst_n(rst_n), .en(en), .baud_tick(baud_tick), .ser_in(ser_in),
    .mode_ask(mode_ask), .ir_sel(ir_sel), .txd_out(txd_n));

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: txd actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic one_cycle(input bit b, input int j, input int s);
    bit e;
    string tag;
    @(negedge clk);
    baud_tick = (s == 0);
    ser_in = b;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    if (mode_ask) e = en && !b && (((j * TD + s) / HALF_EXP) % 2 == 0);
    else          e = en && !b && (j < PULSE);
    if (!ir_sel)          tag = "R7";
    else if (!en)         tag = "R6";
    else if (b)           tag = "R3";
    else if (!prev_b)     tag = "R5";
    else if (mode_ask)    tag = "R4/R9";
    else                  tag = "R2/R9";
    check(txd_p, ir_sel ? e : b, tag);
    check(txd_n, ir_sel ? !e : b, ir_sel ? "R8" : "R7");
  endtask

  task automatic send_bit(input bit b);
    for (int j = 0; j < NTICK; j++)
      for (int s = 0; s < TD; s++)
        one_cycle(b, j, s);
    prev_b = b;
  endtask

  task automatic send_frame(input logic [7:0] d);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    check(txd_p, 1'b0, "R1");
    check(txd_n, 1'b1, "R1");
    send_bit(1'b1);
    send_bit(1'b1);
    for (int m = 0; m < 2; m++) begin
      mode_ask = m[0];
      send_frame(8'h00);
      send_frame(8'hFF);
      send_frame(8'h55);
      send_frame(8'hA3);
      send_frame(8'h0F);
      for (int d = 0; d < 256; d += 9) send_frame(8'(d));
      en = 1'b0;
      send_frame(8'h12);
      en = 1'b1;
      ir_sel = 1'b0;
      send_frame(8'h6C);
      en = 1'b0;
      send_frame(8'h91);
      en = 1'b1;
      ir_sel = 1'b1;
      send_bit(1'b1);
    end
    mode_ask = 1'b0;
    send_bit(1'b0);
    mode_ask = 1'b1;
    send_bit(1'b0);
    send_bit(1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule